// File: doc/BRIEF.md
# Oscillator Clock Controller

This block produces the clock enables that pace a small 4-bit microcontroller core. Everything runs on the raw oscillator clock. The block keeps a 4-bit control word that software can read and write. The top bit of that word selects the system clock rate: either every oscillator cycle, or every second oscillator cycle. A fixed divide-by-3 stage then turns the system clock pulses into instruction clock pulses. Both rates are single-cycle enable pulses, not derived clocks, so the whole block stays in one clock domain.

A power-off request sets a stop latch, which turns the oscillator off through `osc_run`. Two kinds of event clear the latch: a wake event or a reset. A wake event is a falling edge on an enabled key input, or an interrupt pin at its selected active level. A wake event also reloads the control word. After any restart, a counter waits a fixed number of oscillator cycles so the oscillator can settle. Until the count ends, `clk_ready` stays low and no enables are issued.

Top module: `osc_clock_ctrl`

## Requirements
- R1: During reset and just after it, the outputs are as follows. `ctl_rdata` reads 4'b1000. `osc_run` is 1. `clk_ready`, `sys_ce` and `inst_ce` are 0. `speed_mid` is 1.
- R2: `clk_ready` rises on the WAIT_CYCLES-th clock edge after reset is released or after a wake restart, and not before. `sys_ce` and `inst_ce` stay 0 while `clk_ready` is 0.
- R3: Writes set all four bits of the control word, including bits 0 to 2, which have no function. A read on `ctl_rdata` returns the last written value on the cycle after the write.
- R4: With bit 3 = 1 (middle speed), `sys_ce` pulses every 2nd cycle and `inst_ce` every 6th. The first `inst_ce` comes 6 cycles after `clk_ready` rises. With bit 3 = 0 (high speed), `sys_ce` pulses every cycle and `inst_ce` every 3rd cycle.
- R5: A change to bit 3 takes effect only at the next instruction cycle boundary. Gaps between `inst_ce` pulses are always exactly 3 or 6 cycles. `speed_mid` is unchanged on the cycle after the write.
- R6: `pof_req` stops the clock. `osc_run` and `clk_ready` go to 0, no enables are issued, and the control word is kept.
- R7: While stopped, a 1-to-0 transition on a key input whose `key_en` bit is 1 wakes the block. A falling edge on a disabled key does not wake it, and neither does a rising edge.
- R8: While stopped, interrupt pin i wakes the block when `irq_pin[i]` equals `irq_pol[i]`. A polarity bit of 1 means high is active; 0 means low is active.
- R9: A wake event while the clock is running has no effect on `clk_ready`, the control word or the enable pattern.
- R10: A wake restart reloads the control word to 4'b1000.
- R11: If a power-off request and a wake event occur in the same cycle, the wake event wins. A stopped block restarts, and a running block keeps running.
- R12: Reset clears the stop latch and restarts the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Raw oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word write data |
| ctl_rdata | output | 4 | Current control word |
| pof_req | input | 1 | Power-off request, one cycle |
| key_in | input | NKEY | Key wake inputs, idle high |
| key_en | input | NKEY | Per-key wake enable |
| irq_pin | input | 2 | External interrupt pins |
| irq_pol | input | 2 | Active level per interrupt pin (1 = high) |
| osc_run | output | 1 | Oscillator enable (0 while stopped) |
| clk_ready | output | 1 | Stabilization wait complete |
| sys_ce | output | 1 | System clock enable pulse |
| inst_ce | output | 1 | Instruction clock enable pulse |
| speed_mid | output | 1 | Rate in effect: 1 = half rate |

## Verification
Timing is counted from the clock edge that captures an input:
- A stop, a wake, a control write and the control reload all show one edge later.
- `clk_ready` rises exactly WAIT_CYCLES edges after a reset release or a restart.
- The first instruction pulse follows 6 edges later in middle speed.
- Enable outputs fall one edge after `clk_ready` falls.

The bench drives inputs on the falling clock edge and samples outputs on the next falling edge. It checks `clk_ready` on the cycle before its due edge and again on that edge. It measures pulse gaps as counts of falling edges. When no fixed phase can be predicted, as during a rate switch, it checks the set of legal gaps instead of a single value.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int CTL_W     = 4;
  localparam int SEL_BIT   = 3;
  localparam int IRQ_N     = 2;
  localparam int DIV_LAST  = 2;
  typedef logic [CTL_W-1:0] ctl_word_t;
  localparam ctl_word_t CTL_INIT = 4'b1000;
endpackage

// File: rtl/occ_ctl_reg.sv
module occ_ctl_reg
  import occ_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  ctl_word_t wr_data,
  input  logic      reload,
  output ctl_word_t ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= CTL_INIT;
    end else if (reload) begin
      ctl_q <= CTL_INIT;
    end else if (wr_en) begin
      ctl_q <= wr_data;
    end
  end
endmodule

// File: rtl/occ_wake_det.sv
module occ_wake_det
  import occ_pkg::*;
#(
  parameter int NKEY = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NKEY-1:0]  key_in,
  input  logic [NKEY-1:0]  key_en,
  input  logic [IRQ_N-1:0] irq_pin,
  input  logic [IRQ_N-1:0] irq_pol,
  output logic             wake
);
  logic [NKEY-1:0]  key_q;
  logic [NKEY-1:0]  key_fall;
  logic [IRQ_N-1:0] irq_hit;

  always_ff @(posedge clk) begin
    if (rst) key_q <= '1;
    else     key_q <= key_in;
  end

  genvar gk;
  generate
    for (gk = 0; gk < NKEY; gk++) begin : g_key
      assign key_fall[gk] = key_en[gk] & key_q[gk] & ~key_in[gk];
    end
  endgenerate

  genvar gi;
  generate
    for (gi = 0; gi < IRQ_N; gi++) begin : g_irq
      assign irq_hit[gi] = ~(irq_pin[gi] ^ irq_pol[gi]);
    end
  endgenerate

  assign wake = (|key_fall) | (|irq_hit);

  // R7
  key_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (key_en == '1 && key_in == '1 && irq_hit == '0) |-> !wake);
endmodule

// File: rtl/occ_stop_wait.sv
module occ_stop_wait #(
  parameter int WAIT_CYCLES = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic pof,
  input  logic wake,
  output logic stopped,
  output logic ready,
  output logic restart
);
  localparam int CW = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(WAIT_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign restart = stopped & wake;

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped <= 1'b0;
      ready   <= 1'b0;
      cnt     <= '0;
    end else if (restart) begin
      stopped <= 1'b0;
      ready   <= 1'b0;
      cnt     <= '0;
    end else if (pof && !wake) begin
      stopped <= 1'b1;
      ready   <= 1'b0;
      cnt     <= '0;
    end else if (!stopped && !ready) begin
      if (cnt == CNT_LAST) ready <= 1'b1;
      else                 cnt   <= cnt + 1'b1;
    end
  end

  // R6
  stop_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    stopped |-> !ready);

  // R11
  wake_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (pof && wake) |=> !stopped);

  // R9
  run_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && wake) |=> ready);
endmodule

// File: rtl/occ_divider.sv
module occ_divider
  import occ_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic sel_mid,
  output logic sys_ce,
  output logic inst_ce,
  output logic mode_mid
);
  logic       pre_ph;
  logic [1:0] div_cnt;
  logic       pre_tick;
  logic       cyc_end;

  assign pre_tick = ~mode_mid | pre_ph;
  assign cyc_end  = pre_tick & (div_cnt == 2'(DIV_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_ph   <= 1'b0;
      div_cnt  <= '0;
      mode_mid <= CTL_INIT[SEL_BIT];
      sys_ce   <= 1'b0;
      inst_ce  <= 1'b0;
    end else if (!run) begin
      pre_ph   <= 1'b0;
      div_cnt  <= '0;
      mode_mid <= sel_mid;
      sys_ce   <= 1'b0;
      inst_ce  <= 1'b0;
    end else begin
      sys_ce  <= pre_tick;
      inst_ce <= cyc_end;
      if (cyc_end) begin
        div_cnt  <= '0;
        pre_ph   <= 1'b0;
        mode_mid <= sel_mid;
      end else begin
        if (pre_tick) div_cnt <= div_cnt + 2'd1;
        pre_ph <= mode_mid ? ~pre_ph : 1'b0;
      end
    end
  end

  // R2
  gate_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sys_ce && !inst_ce));

  // R4
  inst_space_chk: assert property (@(posedge clk) disable iff (rst)
    inst_ce |=> !inst_ce);

  // R5
  mode_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_mid != $past(mode_mid)) && $past(run)) |-> inst_ce);
endmodule

// File: rtl/osc_clock_ctrl.sv
module osc_clock_ctrl
  import occ_pkg::*;
#(
  parameter int WAIT_CYCLES = 256,
  parameter int NKEY        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_wdata,
  output logic [3:0]       ctl_rdata,
  input  logic             pof_req,
  input  logic [NKEY-1:0]  key_in,
  input  logic [NKEY-1:0]  key_en,
  input  logic [1:0]       irq_pin,
  input  logic [1:0]       irq_pol,
  output logic             osc_run,
  output logic             clk_ready,
  output logic             sys_ce,
  output logic             inst_ce,
  output logic             speed_mid
);
  ctl_word_t ctl_q;
  logic      wake;
  logic      stopped;
  logic      ready;
  logic      restart;

  occ_ctl_reg u_ctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctl_wr),
    .wr_data (ctl_wdata),
    .reload  (restart),
    .ctl_q   (ctl_q)
  );

  occ_wake_det #(.NKEY(NKEY)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .key_in  (key_in),
    .key_en  (key_en),
    .irq_pin (irq_pin),
    .irq_pol (irq_pol),
    .wake    (wake)
  );

  occ_stop_wait #(.WAIT_CYCLES(WAIT_CYCLES)) u_stop (
    .clk     (clk),
    .rst     (rst),
    .pof     (pof_req),
    .wake    (wake),
    .stopped (stopped),
    .ready   (ready),
    .restart (restart)
  );

  occ_divider u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (ready),
    .sel_mid  (ctl_q[SEL_BIT]),
    .sys_ce   (sys_ce),
    .inst_ce  (inst_ce),
    .mode_mid (speed_mid)
  );

  assign ctl_rdata = ctl_q;
  assign osc_run   = ~stopped;
  assign clk_ready = ready;

  // R10
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stopped) |-> (ctl_q == CTL_INIT));

  // R6
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (stopped && $past(stopped)) |-> (!sys_ce && !inst_ce));
endmodule

// File: tb/test_osc_clock_ctrl.sv
`timescale 1ns/1ps
module test_osc_clock_ctrl;
  localparam int WAITC = 8;
  localparam int NK    = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_wr = 1'b0;
  logic [3:0]    ctl_wdata = '0;
  logic [3:0]    ctl_rdata;
  logic          pof_req = 1'b0;
  logic [NK-1:0] key_in = '1;
  logic [NK-1:0] key_en = '0;
  logic [1:0]    irq_pin = 2'b00;
  logic [1:0]    irq_pol = 2'b11;
  logic          osc_run, clk_ready, sys_ce, inst_ce, speed_mid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  osc_clock_ctrl #(.WAIT_CYCLES(WAITC), .NKEY(NK)) i_osc_clock_ctrl (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .pof_req(pof_req), .key_in(key_in),
    .key_en(key_en), .irq_pin(irq_pin), .irq_pol(irq_pol),
    .osc_run(osc_run), .clk_ready(clk_ready), .sys_ce(sys_ce),
    .inst_ce(inst_ce), .speed_mid(speed_mid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at the negedge just before the first counting edge
  task automatic check_wait(input string tag);
    int seen_ce = 0;
    for (int k = 1; k < WAITC; k++) begin
      cyc(1);
      if (sys_ce || inst_ce) seen_ce++;
    end
    chk(clk_ready == 1'b0, {tag, " R2 ready early"}, clk_ready, 0);
    chk(seen_ce == 0, {tag, " R2 enables during wait"}, seen_ce, 0);
    cyc(1);
    chk(clk_ready == 1'b1, {tag, " R2 ready due"}, clk_ready, 1);
  endtask

  task automatic write_ctl(input logic [3:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    cyc(1);
    ctl_wr = 1'b0;
  endtask

  task automatic gaps(input int n, input int exp, input string tag);
    int last = -1;
    int seen = 0;
    int t = 0;
    while (seen < n && t < 200) begin
      cyc(1); t++;
      if (inst_ce) begin
        if (last >= 0) chk(t - last == exp, tag, t - last, exp);
        last = t; seen++;
      end
    end
    chk(seen == n, {tag, " pulse count"}, seen, n);
  endtask

  task automatic power_off();
    pof_req = 1'b1;
    cyc(1);
    pof_req = 1'b0;
    chk(osc_run == 1'b0, "R6 osc_run after pof", osc_run, 0);
    chk(clk_ready == 1'b0, "R6 ready after pof", clk_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    cyc(3);
    // R1 reset state
    chk(ctl_rdata == 4'b1000, "R1 ctl reset", ctl_rdata, 8);
    chk(osc_run == 1'b1, "R1 osc_run", osc_run, 1);
    chk(clk_ready == 1'b0, "R1 ready", clk_ready, 0);
    chk(sys_ce == 1'b0 && inst_ce == 1'b0, "R1 enables", {sys_ce, inst_ce}, 0);
    chk(speed_mid == 1'b1, "R1 speed_mid", speed_mid, 1);
    rst = 1'b0;
    check_wait("reset");

    // R4 middle-speed phase after ready
    for (int k = 1; k <= 6; k++) begin
      cyc(1);
      chk(sys_ce == ((k % 2) == 0), "R4 mid sys_ce phase", sys_ce, (k % 2) == 0);
      chk(inst_ce == (k == 6), "R4 mid first inst_ce", inst_ce, k == 6);
    end
    gaps(4, 6, "R4 mid inst gap");

    // R5 switch to high speed at boundary
    write_ctl(4'b0000);
    chk(speed_mid == 1'b1, "R5 no immediate switch", speed_mid, 1);
    begin
      int last = -1; int t = 0; int seen = 0;
      while (seen < 4 && t < 100) begin
        cyc(1); t++;
        if (inst_ce) begin
          if (last >= 0) chk((t - last == 3) || (t - last == 6), "R5 legal gap", t - last, 3);
          last = t; seen++;
        end
      end
    end
    chk(speed_mid == 1'b0, "R5 speed_mid high", speed_mid, 0);
    gaps(4, 3, "R4 high inst gap");
    cnt = 0;
    for (int k = 0; k < 12; k++) begin cyc(1); if (sys_ce) cnt++; end
    chk(cnt == 12, "R4 high sys_ce count", cnt, 12);

    // R3 sweep of all register values
    for (int v = 0; v < 16; v++) begin
      write_ctl(4'(v));
      chk(ctl_rdata == 4'(v), "R3 readback", ctl_rdata, v);
    end
    write_ctl(4'b0101);
    cyc(8);

    // R9 wake while running
    irq_pin = 2'b01; cyc(1); irq_pin = 2'b00;
    key_en = '1; key_in = 4'b1110; cyc(1); key_in = '1; key_en = '0;
    chk(osc_run == 1'b1 && clk_ready == 1'b1, "R9 still running", clk_ready, 1);
    chk(ctl_rdata == 4'b0101, "R9 ctl untouched", ctl_rdata, 5);
    gaps(3, 3, "R9 pattern kept");

    // R6 power-off
    power_off();
    cyc(1);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin cyc(1); if (sys_ce || inst_ce || osc_run) cnt++; end
    chk(cnt == 0, "R6 quiet while stopped", cnt, 0);
    chk(ctl_rdata == 4'b0101, "R6 ctl kept", ctl_rdata, 5);

    // R7 disabled key and rising edge do not wake
    key_en = 4'b0001; key_in = 4'b1101; cyc(3);
    chk(osc_run == 1'b0, "R7 disabled key ignored", osc_run, 0);
    key_in = '1;
    key_en = 4'b0000; key_in = 4'b1110; cyc(2);
    key_en = 4'b0001; key_in = 4'b1111; cyc(3);
    chk(osc_run == 1'b0, "R7 rising edge ignored", osc_run, 0);
    key_in = 4'b1110; cyc(1);
    chk(osc_run == 1'b1, "R7 enabled fall wakes", osc_run, 1);
    chk(ctl_rdata == 4'b1000, "R10 reload on wake", ctl_rdata, 8);
    key_in = '1; key_en = '0;
    check_wait("R7 wake");
    chk(speed_mid == 1'b1, "R10 mid after wake", speed_mid, 1);

    // R8 interrupt level sweep
    for (int p = 0; p < 2; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        irq_pol[p] = 1'(pol);
        irq_pin = ~irq_pol;
        cyc(1);
        power_off();
        cyc(3);
        chk(osc_run == 1'b0, "R8 inactive level", osc_run, 0);
        irq_pin[p] = 1'(pol);
        cyc(1);
        irq_pin = ~irq_pol;
        chk(osc_run == 1'b1, "R8 active level wakes", osc_run, 1);
        check_wait("R8 wake");
      end
    end

    // R11 power-off and wake together
    irq_pin[0] = irq_pol[0]; pof_req = 1'b1; cyc(1);
    irq_pin = ~irq_pol; pof_req = 1'b0;
    chk(osc_run == 1'b1 && clk_ready == 1'b1, "R11 running wake wins", clk_ready, 1);
    power_off();
    irq_pin[1] = irq_pol[1]; pof_req = 1'b1; cyc(1);
    irq_pin = ~irq_pol; pof_req = 1'b0;
    chk(osc_run == 1'b1, "R11 stopped wake wins", osc_run, 1);
    check_wait("R11 wake");

    // R12 reset while stopped
    write_ctl(4'b0011);
    power_off();
    rst = 1'b1; cyc(2);
    chk(osc_run == 1'b1, "R12 reset clears stop", osc_run, 1);
    chk(ctl_rdata == 4'b1000, "R12 ctl reset", ctl_rdata, 8);
    rst = 1'b0;
    check_wait("R12 reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule